// File: doc/BRIEF.md
# CompactFlash True IDE PIO Bus Engine

This block sits between a simple host request port and a CompactFlash card wired in True IDE mode on a static-memory style bus. Each host request carries a 24-bit chip-select-relative address, a direction, a width flag and write data. The top three address bits choose the card mode. Only the two True IDE modes start a bus cycle: the task-file window and the alternate-status/control window. Each bus access runs with a programmable setup, strobe length and total length, all counted in system clocks.

The data register and the task-file registers share one register address. The width flag on each request decides whether the access is a 16-bit data transfer or an 8-bit register access. The device can lengthen the strobe by pulling IORDY low. After every read, the bus is left floating for a programmable number of clocks before the block accepts the next request. An optional board-level swap of register address bits 0 and 2 is applied on the way out. A host that knows nanosecond timings converts them to clock counts and loads them through the configuration port.

Top module: `cf_ide_pio_engine`

## Requirements
- R1: A request whose `req_addr[23:21]` is 3'b110 runs a bus cycle with `ide_alt`=0. A request with 3'b111 runs one with `ide_alt`=1. In both cases `ide_addr` carries `req_addr[2:0]`, held for the whole cycle.
- R2: A request with any other value in `req_addr[23:21]` is accepted but drives no bus cycle: `ide_cs_n` stays high, and `rsp_valid` pulses in the next clock with `rsp_rdata`=0.
- R3: `req_wide`=1 gives a 16-bit access (`ide_wide`=1) and returns all 16 bits of `ide_din`. `req_wide`=0 gives an 8-bit access (`ide_wide`=0) and returns `ide_din[7:0]` with the upper byte zero.
- R4: `ide_cs_n` goes low in the clock after acceptance and stays low for exactly the cycle count. The strobe (`ide_rd_n` for a read, `ide_wr_n` for a write) goes low after the setup count and stays low for the pulse count. The other strobe stays high.
- R5: During a write, `ide_doe` is high and `ide_dout` equals `req_wdata` for every clock that `ide_cs_n` is low. A read never raises `ide_doe`.
- R6: With IORDY waiting enabled, each rising clock edge that samples `ide_iordy` low while the strobe is active lengthens both the strobe and the chip-select time by one clock. With waiting disabled, `ide_iordy` has no effect.
- R7: After a read, `req_ready` stays low for the float count beyond the end of the cycle. After a write, `req_ready` returns in the clock in which `ide_cs_n` rises.
- R8: `rsp_valid` pulses for one clock in the clock in which `ide_cs_n` rises. For a read, `rsp_rdata` holds `ide_din` as sampled on the edge that ends the strobe.
- R9: With the swap flag set, the register address is driven with bits 0 and 2 exchanged. For example, offset 1 appears as 4, offset 3 as 6, and alternate offset 6 as 3.
- R10: A pulse count of 0 is used as 1. A cycle count below setup plus the used pulse count is raised to that sum.
- R11: After reset, `req_ready` is high, all strobes and `ide_cs_n` are high, and `ide_doe` and `rsp_valid` are low. The counts are setup 7, pulse 17, cycle 60, float 3, with IORDY waiting and swap off.
- R12: A configuration write with `cfg_we`=1 stores `cfg_wdata` according to `cfg_sel`: 0 setup, 1 pulse, 2 cycle, 3 float, 4 flags (bit 0 IORDY wait enable, bit 1 address swap). The stored value applies to every request accepted after the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 3 | Configuration register select |
| cfg_wdata | input | 8 | Configuration write value |
| req_valid | input | 1 | Host request valid |
| req_ready | output | 1 | Engine can accept a request |
| req_addr | input | 24 | Chip-select-relative address |
| req_write | input | 1 | 1 = write, 0 = read |
| req_wide | input | 1 | 1 = 16-bit data access, 0 = 8-bit register access |
| req_wdata | input | 16 | Write data |
| rsp_valid | output | 1 | One-clock completion pulse |
| rsp_rdata | output | 16 | Read data |
| ide_cs_n | output | 1 | Card chip select, active low |
| ide_alt | output | 1 | 1 = alternate-status/control window |
| ide_rd_n | output | 1 | Read strobe, active low |
| ide_wr_n | output | 1 | Write strobe, active low |
| ide_addr | output | 3 | Register address |
| ide_wide | output | 1 | 16-bit access indicator |
| ide_dout | output | 16 | Data driven to the card |
| ide_doe | output | 1 | Output enable for `ide_dout` |
| ide_din | input | 16 | Data from the card |
| ide_iordy | input | 1 | Device ready, low stretches the strobe |

## Verification
A timing counter that is off by one shows up at once as a chip-select or strobe window one clock too long or too short, inside the access where it happens. A stale timing snapshot shows as wrong windows on the first access after a configuration write. A wrong state after the cycle shows as `req_ready` returning too early or too late, within the float count after the cycle. A bad capture point shows as wrong read data in the response pulse of that same access. A wrong address-decode or swap path shows on `ide_addr`/`ide_alt` from the first clock of chip select.

// File: rtl/cf_ide_pkg.sv
// Shared constants and types for the CompactFlash True IDE PIO engine.
// Assumes the card-mode field is the top three bits of a 24-bit window.
package cf_ide_pkg;

    typedef enum logic [1:0] {
        SEQ_IDLE   = 2'd0,
        SEQ_ACTIVE = 2'd1,
        SEQ_FLOAT  = 2'd2
    } seq_state_e;

    localparam logic [2:0] MODE_TASKFILE = 3'b110;
    localparam logic [2:0] MODE_ALTSTAT  = 3'b111;

    localparam logic [2:0] CFG_SETUP = 3'd0;
    localparam logic [2:0] CFG_PULSE = 3'd1;
    localparam logic [2:0] CFG_CYCLE = 3'd2;
    localparam logic [2:0] CFG_FLOAT = 3'd3;
    localparam logic [2:0] CFG_FLAGS = 3'd4;

endpackage

// File: rtl/cf_ide_cfg_regs.sv
// Timing/flag configuration registers with clamping of the derived limits.
// Assumes writes arrive one per clock; outputs are the clamped values that
// the sequencer snapshots when it accepts a request.
module cf_ide_cfg_regs
    import cf_ide_pkg::*;
#(
    parameter int CNT_W     = 8,
    parameter int RST_SETUP = 7,
    parameter int RST_PULSE = 17,
    parameter int RST_CYCLE = 60,
    parameter int RST_FLOAT = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_we_i,
    input  logic [2:0]       cfg_sel_i,
    input  logic [CNT_W-1:0] cfg_wdata_i,
    output logic [CNT_W-1:0] setup_o,
    output logic [CNT_W:0]   strobe_end_o,
    output logic [CNT_W:0]   cycle_end_o,
    output logic [CNT_W-1:0] float_o,
    output logic             iordy_en_o,
    output logic             swap_o
);

    logic [CNT_W-1:0] setup_q, pulse_q, cycle_q, float_q;
    logic             iordy_en_q, swap_q;
    logic [CNT_W-1:0] pulse_eff;
    logic [CNT_W:0]   sum, cyc_ext;

    // Register file update on configuration writes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            setup_q    <= CNT_W'(RST_SETUP);
            pulse_q    <= CNT_W'(RST_PULSE);
            cycle_q    <= CNT_W'(RST_CYCLE);
            float_q    <= CNT_W'(RST_FLOAT);
            iordy_en_q <= 1'b0;
            swap_q     <= 1'b0;
        end else if (cfg_we_i) begin
            case (cfg_sel_i)
                CFG_SETUP: setup_q <= cfg_wdata_i;
                CFG_PULSE: pulse_q <= cfg_wdata_i;
                CFG_CYCLE: cycle_q <= cfg_wdata_i;
                CFG_FLOAT: float_q <= cfg_wdata_i;
                CFG_FLAGS: begin
                    iordy_en_q <= cfg_wdata_i[0];
                    swap_q     <= cfg_wdata_i[1];
                end
                default: ;
            endcase
        end
    end

    // Clamp pulse to at least one clock and cycle to cover setup plus pulse.
    always_comb begin
        pulse_eff = (pulse_q == '0) ? CNT_W'(1) : pulse_q;
        sum       = {1'b0, setup_q} + {1'b0, pulse_eff};
        cyc_ext   = {1'b0, cycle_q};
        cycle_end_o  = (cyc_ext < sum) ? sum : cyc_ext;
        strobe_end_o = sum;
    end

    assign setup_o    = setup_q;
    assign float_o    = float_q;
    assign iordy_en_o = iordy_en_q;
    assign swap_o     = swap_q;

endmodule

// File: rtl/cf_ide_addr_map.sv
// Decodes the card-mode field and forms the register address, with the
// optional exchange of address bits 0 and 2. Purely combinational.
module cf_ide_addr_map
    import cf_ide_pkg::*;
#(
    parameter int ADDR_W = 24
) (
    input  logic [ADDR_W-1:0] addr_i,
    input  logic              swap_i,
    output logic              mode_ok_o,
    output logic              alt_o,
    output logic [2:0]        reg_o
);

    localparam int MODE_LSB = ADDR_W - 3;

    logic [2:0] mode;

    // Mode decode and optional bit swap of the register offset.
    always_comb begin
        mode      = addr_i[ADDR_W-1:MODE_LSB];
        mode_ok_o = (mode == MODE_TASKFILE) || (mode == MODE_ALTSTAT);
        alt_o     = (mode == MODE_ALTSTAT);
        reg_o     = swap_i ? {addr_i[0], addr_i[1], addr_i[2]} : addr_i[2:0];
    end

endmodule

// File: rtl/cf_ide_bus_seq.sv
// Bus-cycle sequencer: snapshots timing at acceptance, runs chip select for
// the cycle count, places the strobe after setup, freezes on IORDY low when
// enabled, captures read data as the strobe ends, then holds a float gap.
// Assumes start_i and skip_i are only raised while busy_o is low.
module cf_ide_bus_seq
    import cf_ide_pkg::*;
#(
    parameter int CNT_W  = 8,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic              skip_i,
    input  logic              write_i,
    input  logic              wide_i,
    input  logic              alt_i,
    input  logic [2:0]        reg_i,
    input  logic [DATA_W-1:0] wdata_i,
    input  logic [CNT_W-1:0]  setup_i,
    input  logic [CNT_W:0]    strobe_end_i,
    input  logic [CNT_W:0]    cycle_end_i,
    input  logic [CNT_W-1:0]  float_i,
    input  logic              iordy_en_i,
    output logic              busy_o,
    output logic              rsp_valid_o,
    output logic [DATA_W-1:0] rsp_rdata_o,
    output logic              ide_cs_n_o,
    output logic              ide_alt_o,
    output logic              ide_rd_n_o,
    output logic              ide_wr_n_o,
    output logic [2:0]        ide_addr_o,
    output logic              ide_wide_o,
    output logic [DATA_W-1:0] ide_dout_o,
    output logic              ide_doe_o,
    input  logic [DATA_W-1:0] ide_din_i,
    input  logic              ide_iordy_i
);

    seq_state_e        st_q;
    logic [CNT_W:0]    cnt_q;
    logic [CNT_W-1:0]  fcnt_q;
    logic [CNT_W:0]    s_setup_q, s_strobe_end_q, s_cycle_end_q;
    logic [CNT_W-1:0]  s_float_q;
    logic              s_iordy_en_q, s_write_q, s_wide_q, s_alt_q;
    logic [2:0]        s_reg_q;
    logic [DATA_W-1:0] s_wdata_q, rdata_q;
    logic              rsp_q;
    logic              strobe_on, stall;

    // Strobe window and IORDY stall condition for the current count.
    always_comb begin
        strobe_on = (st_q == SEQ_ACTIVE) && (cnt_q >= s_setup_q) && (cnt_q < s_strobe_end_q);
        stall     = strobe_on && s_iordy_en_q && !ide_iordy_i;
    end

    // Main sequencer: acceptance snapshot, counting, capture and float gap.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q           <= SEQ_IDLE;
            cnt_q          <= '0;
            fcnt_q         <= '0;
            s_setup_q      <= '0;
            s_strobe_end_q <= '0;
            s_cycle_end_q  <= '0;
            s_float_q      <= '0;
            s_iordy_en_q   <= 1'b0;
            s_write_q      <= 1'b0;
            s_wide_q       <= 1'b0;
            s_alt_q        <= 1'b0;
            s_reg_q        <= '0;
            s_wdata_q      <= '0;
            rdata_q        <= '0;
            rsp_q          <= 1'b0;
        end else begin
            rsp_q <= 1'b0;
            case (st_q)
                SEQ_IDLE: begin
                    if (start_i) begin
                        st_q           <= SEQ_ACTIVE;
                        cnt_q          <= '0;
                        s_setup_q      <= {1'b0, setup_i};
                        s_strobe_end_q <= strobe_end_i;
                        s_cycle_end_q  <= cycle_end_i;
                        s_float_q      <= float_i;
                        s_iordy_en_q   <= iordy_en_i;
                        s_write_q      <= write_i;
                        s_wide_q       <= wide_i;
                        s_alt_q        <= alt_i;
                        s_reg_q        <= reg_i;
                        s_wdata_q      <= wdata_i;
                    end else if (skip_i) begin
                        rsp_q   <= 1'b1;
                        rdata_q <= '0;
                    end
                end
                SEQ_ACTIVE: begin
                    if (!stall) begin
                        if (strobe_on && !s_write_q && (cnt_q == s_strobe_end_q - 1'b1)) begin
                            rdata_q <= s_wide_q ? ide_din_i
                                                : {{(DATA_W-8){1'b0}}, ide_din_i[7:0]};
                        end
                        if (cnt_q == s_cycle_end_q - 1'b1) begin
                            rsp_q <= 1'b1;
                            if (!s_write_q && (s_float_q != '0)) begin
                                st_q   <= SEQ_FLOAT;
                                fcnt_q <= s_float_q;
                            end else begin
                                st_q <= SEQ_IDLE;
                            end
                        end else begin
                            cnt_q <= cnt_q + 1'b1;
                        end
                    end
                end
                SEQ_FLOAT: begin
                    if (fcnt_q == CNT_W'(1)) st_q <= SEQ_IDLE;
                    fcnt_q <= fcnt_q - 1'b1;
                end
                default: st_q <= SEQ_IDLE;
            endcase
        end
    end

    assign busy_o      = (st_q != SEQ_IDLE);
    assign rsp_valid_o = rsp_q;
    assign rsp_rdata_o = rdata_q;
    assign ide_cs_n_o  = (st_q != SEQ_ACTIVE);
    assign ide_rd_n_o  = !(strobe_on && !s_write_q);
    assign ide_wr_n_o  = !(strobe_on && s_write_q);
    assign ide_doe_o   = (st_q == SEQ_ACTIVE) && s_write_q;
    assign ide_dout_o  = s_wdata_q;
    assign ide_alt_o   = s_alt_q;
    assign ide_addr_o  = s_reg_q;
    assign ide_wide_o  = s_wide_q;

    // A strobe is only ever low inside chip select (R4).
    p_strobe_in_cs_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!ide_rd_n_o || !ide_wr_n_o) |-> !ide_cs_n_o);

    // Read and write strobes are never low together (R4).
    p_one_strobe_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !(!ide_rd_n_o && !ide_wr_n_o));

    // A stalled strobe is still active one clock later (R6).
    p_stall_holds_r6: assert property (@(posedge clk) disable iff (!rst_n)
        stall |=> strobe_on);

    // The completion pulse coincides with chip select rising (R8).
    p_rsp_at_cs_end_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ide_cs_n_o) |-> rsp_valid_o);

    // Output enable only starts together with chip select (R5).
    p_doe_with_cs_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ide_doe_o) |-> $fell(ide_cs_n_o));

endmodule

// File: rtl/cf_ide_pio_engine.sv
// Top of the CompactFlash True IDE PIO engine: host valid/ready request
// port, configuration port and card bus. Assumes one outstanding request.
module cf_ide_pio_engine
    import cf_ide_pkg::*;
#(
    parameter int ADDR_W    = 24,
    parameter int DATA_W    = 16,
    parameter int CNT_W     = 8,
    parameter int RST_SETUP = 7,
    parameter int RST_PULSE = 17,
    parameter int RST_CYCLE = 60,
    parameter int RST_FLOAT = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [2:0]        cfg_sel,
    input  logic [CNT_W-1:0]  cfg_wdata,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic              req_write,
    input  logic              req_wide,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              rsp_valid,
    output logic [DATA_W-1:0] rsp_rdata,
    output logic              ide_cs_n,
    output logic              ide_alt,
    output logic              ide_rd_n,
    output logic              ide_wr_n,
    output logic [2:0]        ide_addr,
    output logic              ide_wide,
    output logic [DATA_W-1:0] ide_dout,
    output logic              ide_doe,
    input  logic [DATA_W-1:0] ide_din,
    input  logic              ide_iordy
);

    logic [CNT_W-1:0] setup_w, float_w;
    logic [CNT_W:0]   strobe_end_w, cycle_end_w;
    logic             iordy_en_w, swap_w;
    logic             mode_ok_w, alt_w, busy_w, accept;
    logic [2:0]       reg_w;

    cf_ide_cfg_regs #(
        .CNT_W(CNT_W), .RST_SETUP(RST_SETUP), .RST_PULSE(RST_PULSE),
        .RST_CYCLE(RST_CYCLE), .RST_FLOAT(RST_FLOAT)
    ) cfg_i (
        .clk(clk), .rst_n(rst_n), .cfg_we_i(cfg_we), .cfg_sel_i(cfg_sel),
        .cfg_wdata_i(cfg_wdata), .setup_o(setup_w), .strobe_end_o(strobe_end_w),
        .cycle_end_o(cycle_end_w), .float_o(float_w), .iordy_en_o(iordy_en_w),
        .swap_o(swap_w)
    );

    cf_ide_addr_map #(.ADDR_W(ADDR_W)) map_i (
        .addr_i(req_addr), .swap_i(swap_w), .mode_ok_o(mode_ok_w),
        .alt_o(alt_w), .reg_o(reg_w)
    );

    assign req_ready = !busy_w;
    assign accept    = req_valid && req_ready;

    cf_ide_bus_seq #(.CNT_W(CNT_W), .DATA_W(DATA_W)) seq_i (
        .clk(clk), .rst_n(rst_n),
        .start_i(accept && mode_ok_w), .skip_i(accept && !mode_ok_w),
        .write_i(req_write), .wide_i(req_wide), .alt_i(alt_w), .reg_i(reg_w),
        .wdata_i(req_wdata), .setup_i(setup_w), .strobe_end_i(strobe_end_w),
        .cycle_end_i(cycle_end_w), .float_i(float_w), .iordy_en_i(iordy_en_w),
        .busy_o(busy_w), .rsp_valid_o(rsp_valid), .rsp_rdata_o(rsp_rdata),
        .ide_cs_n_o(ide_cs_n), .ide_alt_o(ide_alt), .ide_rd_n_o(ide_rd_n),
        .ide_wr_n_o(ide_wr_n), .ide_addr_o(ide_addr), .ide_wide_o(ide_wide),
        .ide_dout_o(ide_dout), .ide_doe_o(ide_doe), .ide_din_i(ide_din),
        .ide_iordy_i(ide_iordy)
    );

    // A request outside the True IDE modes completes without a bus cycle (R2).
    p_skip_no_bus_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && !mode_ok_w) |=> (rsp_valid && ide_cs_n));

    // The host side is only ready while the card bus is idle (R7).
    p_ready_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> ide_cs_n);

endmodule

// File: tb/cf_ide_pio_engine_tb_top.sv
`timescale 1ns/1ps
module cf_ide_pio_engine_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [2:0]  cfg_sel = '0;
    logic [7:0]  cfg_wdata = '0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [23:0] req_addr = '0;
    logic        req_write = 1'b0;
    logic        req_wide = 1'b0;
    logic [15:0] req_wdata = '0;
    logic        rsp_valid;
    logic [15:0] rsp_rdata;
    logic        ide_cs_n, ide_alt, ide_rd_n, ide_wr_n, ide_wide, ide_doe;
    logic [2:0]  ide_addr;
    logic [15:0] ide_dout;
    logic [15:0] ide_din = 16'hA55A;
    logic        ide_iordy = 1'b1;

    int n_tests = 0;
    int n_fail  = 0;

    // Observations of one access
    int cs_cnt, rd_first, rd_cnt, wr_first, wr_cnt, rsp_k, rdy_k, doe_cnt, dout_bad;
    logic [15:0] got_rdata;
    logic [2:0]  got_addr;
    logic        got_alt, got_wide;

    always #2 clk = ~clk;

    cf_ide_pio_engine dut_i (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
        .cfg_wdata(cfg_wdata), .req_valid(req_valid), .req_ready(req_ready),
        .req_addr(req_addr), .req_write(req_write), .req_wide(req_wide),
        .req_wdata(req_wdata), .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
        .ide_cs_n(ide_cs_n), .ide_alt(ide_alt), .ide_rd_n(ide_rd_n),
        .ide_wr_n(ide_wr_n), .ide_addr(ide_addr), .ide_wide(ide_wide),
        .ide_dout(ide_dout), .ide_doe(ide_doe), .ide_din(ide_din),
        .ide_iordy(ide_iordy)
    );

    task automatic chk(input string tag, input int act, input int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d (0x%0h) expected %0d (0x%0h)", tag, act, act, exp, exp);
        end
    endtask

    task automatic cfg_write(input logic [2:0] sel, input logic [7:0] val);
        @(negedge clk);
        cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = val;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    // Issue one request and record the bus behaviour, one sample per clock.
    task automatic do_access(input logic wr, input logic wide, input logic [23:0] a,
                             input logic [15:0] wd, input int rel_k);
        cs_cnt = 0; rd_first = -1; rd_cnt = 0; wr_first = -1; wr_cnt = 0;
        rsp_k = -1; rdy_k = -1; doe_cnt = 0; dout_bad = 0; got_rdata = '0;
        @(negedge clk);
        req_valid = 1'b1; req_write = wr; req_wide = wide; req_addr = a; req_wdata = wd;
        if (rel_k >= 0) ide_iordy = 1'b0;
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        for (int k = 0; k < 2000; k++) begin
            if (k == rel_k) ide_iordy = 1'b1;
            if (k == 0) begin got_addr = ide_addr; got_alt = ide_alt; got_wide = ide_wide; end
            if (!ide_cs_n) cs_cnt++;
            if (!ide_rd_n) begin if (rd_first < 0) rd_first = k; rd_cnt++; end
            if (!ide_wr_n) begin if (wr_first < 0) wr_first = k; wr_cnt++; end
            if (ide_doe) begin doe_cnt++; if (ide_dout != wd) dout_bad++; end
            if (rsp_valid && rsp_k < 0) begin rsp_k = k; got_rdata = rsp_rdata; end
            if (req_ready) begin rdy_k = k; break; end
            @(negedge clk);
        end
        ide_iordy = 1'b1;
        if (rdy_k < 0) chk("access watchdog", 0, 1);
    endtask

    task automatic t_reset;
        @(negedge clk);
        chk("R11 ready after reset", req_ready, 1);
        chk("R11 cs_n after reset", ide_cs_n, 1);
        chk("R11 rd_n/wr_n after reset", {ide_rd_n, ide_wr_n}, 2'b11);
        chk("R11 doe/rsp after reset", {ide_doe, rsp_valid}, 2'b00);
    endtask

    task automatic t_default_read;
        do_access(1'b0, 1'b1, 24'hC00000, 16'h0, -1);
        chk("R11 default cycle length", cs_cnt, 60);
        chk("R11 default setup", rd_first, 7);
        chk("R11 default pulse", rd_cnt, 17);
        chk("R8 rsp at cs end", rsp_k, 60);
        chk("R7 default float", rdy_k, 63);
        chk("R3 wide read data", got_rdata, 16'hA55A);
        chk("R5 no doe on read", doe_cnt, 0);
    endtask

    task automatic t_prog_write;
        cfg_write(3'd0, 8'd2); cfg_write(3'd1, 8'd3);
        cfg_write(3'd2, 8'd10); cfg_write(3'd3, 8'd2);
        do_access(1'b1, 1'b1, 24'hC00000, 16'h1234, -1);
        chk("R12 programmed cycle", cs_cnt, 10);
        chk("R4 write strobe start", wr_first, 2);
        chk("R4 write strobe length", wr_cnt, 3);
        chk("R4 no read strobe on write", rd_cnt, 0);
        chk("R5 doe for whole cycle", doe_cnt, 10);
        chk("R5 dout matches", dout_bad, 0);
        chk("R3 wide flag", got_wide, 1);
        chk("R8 write rsp", rsp_k, 10);
        chk("R7 no float after write", rdy_k, 10);
    endtask

    task automatic t_narrow_read;
        do_access(1'b0, 1'b0, 24'hC00007, 16'h0, -1);
        chk("R1 taskfile addr", got_addr, 7);
        chk("R1 taskfile window", got_alt, 0);
        chk("R3 narrow flag", got_wide, 0);
        chk("R3 narrow data zero-extended", got_rdata, 16'h005A);
        chk("R7 programmed float", rdy_k, 12);
    endtask

    task automatic t_alt_window;
        do_access(1'b0, 1'b0, 24'hE00006, 16'h0, -1);
        chk("R1 alt window", got_alt, 1);
        chk("R1 alt addr", got_addr, 6);
    endtask

    task automatic t_swap;
        cfg_write(3'd4, 8'h02);
        do_access(1'b0, 1'b0, 24'hC00001, 16'h0, -1);
        chk("R9 swap offset 1", got_addr, 4);
        do_access(1'b0, 1'b0, 24'hC00003, 16'h0, -1);
        chk("R9 swap offset 3", got_addr, 6);
        do_access(1'b0, 1'b0, 24'hE00006, 16'h0, -1);
        chk("R9 swap alt offset 6", got_addr, 3);
        cfg_write(3'd4, 8'h00);
    endtask

    task automatic t_clamp;
        cfg_write(3'd1, 8'd0); cfg_write(3'd2, 8'd1);
        do_access(1'b0, 1'b1, 24'hC00000, 16'h0, -1);
        chk("R10 zero pulse used as one", rd_cnt, 1);
        chk("R10 clamp setup kept", rd_first, 2);
        chk("R10 cycle raised", cs_cnt, 3);
        cfg_write(3'd1, 8'd3); cfg_write(3'd2, 8'd10);
    endtask

    task automatic t_iordy;
        cfg_write(3'd4, 8'h01);
        do_access(1'b0, 1'b1, 24'hC00000, 16'h0, 4);
        chk("R6 strobe stretched", rd_cnt, 5);
        chk("R6 cycle stretched", cs_cnt, 12);
        chk("R6 stretched rsp", rsp_k, 12);
        cfg_write(3'd4, 8'h00);
        do_access(1'b0, 1'b1, 24'hC00000, 16'h0, 1000);
        chk("R6 iordy ignored strobe", rd_cnt, 3);
        chk("R6 iordy ignored cycle", cs_cnt, 10);
    endtask

    task automatic t_invalid_mode;
        do_access(1'b0, 1'b1, 24'h200005, 16'h0, -1);
        chk("R2 no chip select", cs_cnt, 0);
        chk("R2 rsp next clock", rsp_k, 0);
        chk("R2 zero data", got_rdata, 0);
        chk("R2 ready kept", rdy_k, 0);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        t_default_read();
        t_prog_write();
        t_narrow_read();
        t_alt_window();
        t_swap();
        t_clamp();
        t_iordy();
        t_invalid_mode();
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        #400000;
        n_tests++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule